// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency pulse train. It counts rising edges of the pulse input during a gate window of fixed length. Before each window it waits a fixed settling time. The sampling clock also serves as the timing reference: `CLK_PER_MS` clock cycles make one millisecond. A control bit starts a measurement on its rising edge and clears the block while it is low. Two select bits set the gate length.

When the window closes, the block raises a done flag and holds the count until the control bit drops. The result is exposed as a counter word for a serial read-out path. The block also drives a pull-down request for a shared open-drain status pin. The pin function is chosen by a three-bit selector: unlock indication, end of count, SD indication, stereo indication, or open. The pin is always released while the serial bus is selected.

Top module: `if_gate_counter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `if_count` is 0 and `count_done` and `do_pull_low` are 0.
- R2: When `start_en` is first sampled high at clock edge E, the block waits a settle time of 3.5 ms (`(7*CLK_PER_MS)/2` cycles, W). It then opens a gate of G cycles. `count_done` rises right after edge E+W+G and is still 0 right after edge E+W+G-1.
- R3: `gate_sel` sets G = (4 << gate_sel) * `CLK_PER_MS`: 00 gives 4 ms, 01 gives 8 ms, 10 gives 16 ms and 11 gives 32 ms. It is captured at edge E, so later changes do not affect the running measurement.
- R4: `if_count` (CNT_W bits, default 20, bit CNT_W-1 is the MSB) equals the number of rising edges of `if_pulse` seen during the G gate cycles. A steady input counts 0.
- R5: The count saturates at all ones instead of wrapping.
- R6: While `start_en` stays high after completion, `if_count` and `count_done` hold, whatever `if_pulse` does.
- R7: At the first edge that samples `start_en` low, `if_count` becomes 0 and `count_done` becomes 0.
- R8: `do_sel` picks the pull-down source, and `do_pull_low` is registered, so it reflects the inputs of the previous edge. The codes are: 001 pulls low when `pll_unlocked` is 1, 010 pulls low when `count_done` is 1, 101 pulls low when `sd_on` is 1, and 110 pulls low when `stereo_on` is 1. Codes 000, 011, 100 and 111 keep the pin released.
- R9: In end-of-count mode, `do_pull_low` rises one cycle after `count_done` rises. It falls one cycle after `count_done` clears, which happens when a new measurement is prepared (low then high on `start_en`).
- R10: While `bus_active` is high at an edge, `do_pull_low` is 0 after that edge, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and timing reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_en | input | 1 | Rising edge starts a measurement, low clears |
| gate_sel | input | 2 | Gate length select |
| do_sel | input | 3 | Status pin function select |
| pll_unlocked | input | 1 | Synthesizer unlock flag |
| stereo_on | input | 1 | Stereo indicator, 1 = stereo |
| sd_on | input | 1 | Station-detect indicator, 1 = detected |
| bus_active | input | 1 | Serial bus chip-select, 1 = transfer running |
| if_pulse | input | 1 | IF pulse train, asynchronous |
| if_count | output | CNT_W | Measured edge count |
| count_done | output | 1 | Measurement finished |
| do_pull_low | output | 1 | Request to pull the status pin low |

## Verification
The done flag is due exactly W+G edges after the first edge that samples the start bit high. The bench counts edges from that point and samples one cycle before and at the due edge, 1 ns after the clock edge. The pulse source uses a period that divides G, so the expected count is G/period (capped at the maximum) whatever the phase. The source is retimed only during the settle wait, which is longer than any period used. The pin request lags its sources by one register, so each selector and indicator pattern is applied at a falling edge and checked after the next rising edge.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_GATE   = 2'd2,
    ST_HELD   = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    DO_OFF0    = 3'd0,
    DO_UNLOCK  = 3'd1,
    DO_END     = 3'd2,
    DO_OFF3    = 3'd3,
    DO_OFF4    = 3'd4,
    DO_SD      = 3'd5,
    DO_STEREO  = 3'd6,
    DO_OFF7    = 3'd7
  } do_mode_e;

  // Gate length in clock cycles for a select value
  function automatic int gate_cycles(input int sel, input int per_ms);
    return (4 << sel) * per_ms;
  endfunction

  // Settle wait: 3.5 ms
  function automatic int settle_cycles(input int per_ms);
    return (7 * per_ms) / 2;
  endfunction

endpackage

// File: rtl/ifc_pulse_sync.sv
module ifc_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic rise_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pulse_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[LAST];
  end

  assign rise_o = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/ifc_gate_seq.sv
module ifc_gate_seq
  import ifc_pkg::*;
#(
  parameter int CLK_PER_MS = 1000,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_en,
  input  logic [SEL_W-1:0] gate_sel,
  output logic             clear_o,
  output logic             count_en_o,
  output logic             done_o
);

  localparam int N_GATES  = 1 << SEL_W;
  localparam int SETTLE   = settle_cycles(CLK_PER_MS);
  localparam int GATE_MAX = gate_cycles(N_GATES - 1, CLK_PER_MS);
  localparam int TMR_W    = $clog2(GATE_MAX + SETTLE + 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE - 1);

  logic [TMR_W-1:0] gate_len [N_GATES];

  generate
    for (genvar g = 0; g < N_GATES; g++) begin : g_len
      assign gate_len[g] = TMR_W'(gate_cycles(g, CLK_PER_MS) - 1);
    end
  endgenerate

  seq_state_e       state_q, state_d;
  logic [TMR_W-1:0] timer_q, timer_d;
  logic [SEL_W-1:0] sel_q,   sel_d;
  logic             start_q;
  logic             rise;
  logic             tmr_en;
  logic             sel_en;

  assign rise = start_en & ~start_q;

  always_comb begin
    state_d = state_q;
    timer_d = timer_q;
    sel_d   = sel_q;
    if (!start_en) begin
      state_d = ST_IDLE;
      timer_d = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rise) begin
            state_d = ST_SETTLE;
            timer_d = SETTLE_LD;
            sel_d   = gate_sel;
          end
        end
        ST_SETTLE: begin
          if (timer_q == '0) begin
            state_d = ST_GATE;
            timer_d = gate_len[sel_q];
          end else begin
            timer_d = timer_q - 1'b1;
          end
        end
        ST_GATE: begin
          if (timer_q == '0) state_d = ST_HELD;
          else               timer_d = timer_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign tmr_en = (timer_d != timer_q);
  assign sel_en = rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      timer_q <= '0;
    else if (tmr_en) timer_q <= timer_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  assign clear_o    = ~start_en | rise;
  assign count_en_o = (state_q == ST_GATE);
  assign done_o     = (state_q == ST_HELD);

endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         window_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);

  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         full;
  logic         cnt_en;

  assign full = (cnt_q == FULL);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (window_i && inc_i && !full) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/ifc_do_select.sv
module ifc_do_select
  import ifc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       unlock_i,
  input  logic       done_i,
  input  logic       sd_i,
  input  logic       stereo_i,
  input  logic       bus_i,
  output logic       pull_o
);

  logic pull_q, pull_d;
  logic src;

  always_comb begin
    unique case (do_mode_e'(mode_i))
      DO_UNLOCK: src = unlock_i;
      DO_END:    src = done_i;
      DO_SD:     src = sd_i;
      DO_STEREO: src = stereo_i;
      default:   src = 1'b0;
    endcase
    pull_d = src & ~bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_q <= 1'b0;
    else        pull_q <= pull_d;
  end

  assign pull_o = pull_q;

endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter
  import ifc_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int CLK_PER_MS  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_en,
  input  logic [1:0]       gate_sel,
  input  logic [2:0]       do_sel,
  input  logic             pll_unlocked,
  input  logic             stereo_on,
  input  logic             sd_on,
  input  logic             bus_active,
  input  logic             if_pulse,
  output logic [CNT_W-1:0] if_count,
  output logic             count_done,
  output logic             do_pull_low
);

  logic edge_seen;
  logic clear;
  logic window;
  logic done;

  ifc_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (if_pulse),
    .rise_o  (edge_seen)
  );

  ifc_gate_seq #(.CLK_PER_MS(CLK_PER_MS), .SEL_W(2)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_en   (start_en),
    .gate_sel   (gate_sel),
    .clear_o    (clear),
    .count_en_o (window),
    .done_o     (done)
  );

  ifc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear),
    .window_i (window),
    .inc_i    (edge_seen),
    .count_o  (if_count)
  );

  ifc_do_select u_do (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (do_sel),
    .unlock_i (pll_unlocked),
    .done_i   (done),
    .sd_i     (sd_on),
    .stereo_i (stereo_on),
    .bus_i    (bus_active),
    .pull_o   (do_pull_low)
  );

  assign count_done = done;

endmodule

// File: rtl/if_gate_counter_chk.sv
module if_gate_counter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_en,
  input logic [2:0]       do_sel,
  input logic             bus_active,
  input logic [CNT_W-1:0] if_count,
  input logic             count_done,
  input logic             do_pull_low
);

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_done && start_en) |=> $stable(if_count));

  // R7
  clear_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_en |=> (!count_done && if_count == '0));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_en && $past(start_en)) |-> (if_count >= $past(if_count)));

  // R2
  done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_done |-> $past(start_en));

  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |=> !do_pull_low);

  // R8
  open_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_sel == 3'b000 || do_sel == 3'b011 || do_sel == 3'b100 || do_sel == 3'b111)
      |=> !do_pull_low);

endmodule

bind if_gate_counter if_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_en    (start_en),
  .do_sel      (do_sel),
  .bus_active  (bus_active),
  .if_count    (if_count),
  .count_done  (count_done),
  .do_pull_low (do_pull_low)
);

// File: tb/if_gate_counter_test.sv
module if_gate_counter_test;

  localparam int CLK_PERIOD = 10;
  localparam int MS         = 20;
  localparam int CW         = 8;
  localparam int WAITC      = (7 * MS) / 2;
  localparam int CMAX       = (1 << CW) - 1;

  logic          clk;
  logic          rst_n;
  logic          start_en;
  logic [1:0]    gate_sel;
  logic [2:0]    do_sel;
  logic          pll_unlocked;
  logic          stereo_on;
  logic          sd_on;
  logic          bus_active;
  logic          if_pulse;
  logic [CW-1:0] if_count;
  logic          count_done;
  logic          do_pull_low;

  int  n_cmp = 0;
  int  n_bad = 0;
  int  if_period = 0;
  bit  finished = 0;

  if_gate_counter #(.CNT_W(CW), .CLK_PER_MS(MS), .SYNC_STAGES(2)) uut (
    .clk, .rst_n, .start_en, .gate_sel, .do_sel, .pll_unlocked, .stereo_on,
    .sd_on, .bus_active, .if_pulse, .if_count, .count_done, .do_pull_low
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // IF pulse source, retimed on falling edges
  initial begin
    if_pulse = 1'b0;
    forever begin
      if (if_period == 0) begin
        if_pulse = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = if_period;
        if_pulse = 1'b1;
        repeat (p / 2) @(negedge clk);
        if_pulse = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gate_len(input int gs);
    return (4 << gs) * MS;
  endfunction

  function automatic bit exp_pull(input int sel, input bit unl, input bit dn,
                                  input bit sd, input bit st, input bit ce);
    if (ce) return 1'b0;
    case (sel)
      1:       return unl;
      2:       return dn;
      5:       return sd;
      6:       return st;
      default: return 1'b0;
    endcase
  endfunction

  // Full measurement: returns with done high, start_en still high
  task automatic measure(input int gs, input int p, input int gs_late);
    int g;
    int expc;
    g = gate_len(gs);
    expc = (p == 0) ? 0 : g / p;
    if (expc > CMAX) expc = CMAX;
    @(negedge clk);
    start_en = 1'b0;
    if_period = p;
    @(negedge clk);
    gate_sel = 2'(gs);
    start_en = 1'b1;
    @(posedge clk);
    if (gs_late >= 0) begin
      @(negedge clk);
      gate_sel = 2'(gs_late);
      repeat (WAITC + g - 1) @(posedge clk);
    end else begin
      repeat (WAITC + g - 1) @(posedge clk);
    end
    #1;
    chk(count_done == 1'b0, "R2 done early", count_done, 0);
    @(posedge clk); #1;
    chk(count_done == 1'b1, "R2 done due", count_done, 1);
    if (gs_late >= 0)
      chk(if_count == CW'(expc), "R3 latched gate count", if_count, expc);
    else if (expc == CMAX && p != 0 && g / p > CMAX)
      chk(if_count == CW'(expc), "R5 saturated count", if_count, expc);
    else
      chk(if_count == CW'(expc), "R4 count", if_count, expc);
    repeat (25) @(posedge clk); #1;
    chk(if_count == CW'(expc) && count_done, "R6 result held", if_count, expc);
  endtask

  initial begin
    rst_n = 1'b0; start_en = 1'b0; gate_sel = 2'b00; do_sel = 3'b000;
    pll_unlocked = 1'b0; stereo_on = 1'b0; sd_on = 1'b0; bus_active = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk(if_count == 0, "R1 count in reset", if_count, 0);
    chk(count_done == 0, "R1 done in reset", count_done, 0);
    chk(do_pull_low == 0, "R1 pin in reset", do_pull_low, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(if_count == 0 && count_done == 0 && do_pull_low == 0, "R1 after release",
        {if_count, count_done, do_pull_low}, 0);

    // Gate sweep against pulse periods dividing every gate length
    for (int gs = 0; gs < 4; gs++) begin
      int plist [9] = '{0, 2, 4, 5, 8, 10, 16, 20, 40};
      foreach (plist[i]) measure(gs, plist[i], -1);
    end

    // R3: select changes after start are ignored
    measure(0, 4, 3);
    measure(3, 8, 0);

    // R7: low start bit clears
    @(negedge clk); start_en = 1'b0;
    @(posedge clk); #1;
    chk(if_count == 0, "R7 count cleared", if_count, 0);
    chk(count_done == 0, "R7 done cleared", count_done, 0);

    // R8 / R10: exhaustive pin selector sweep, idle then completed
    for (int dn = 0; dn < 2; dn++) begin
      if (dn == 1) measure(0, 10, -1);
      for (int s = 0; s < 8; s++) begin
        for (int v = 0; v < 16; v++) begin
          bit e;
          @(negedge clk);
          do_sel = 3'(s);
          pll_unlocked = v[0]; sd_on = v[1]; stereo_on = v[2]; bus_active = v[3];
          e = exp_pull(s, v[0], dn[0], v[1], v[2], v[3]);
          @(posedge clk); #1;
          if (v[3]) chk(do_pull_low == e, "R10 bus release", do_pull_low, e);
          else      chk(do_pull_low == e, "R8 pin select", do_pull_low, e);
        end
      end
    end

    // R9: end-of-count mode timing
    @(negedge clk);
    do_sel = 3'b010; bus_active = 1'b0; pll_unlocked = 1'b0; sd_on = 1'b0; stereo_on = 1'b0;
    start_en = 1'b0;
    if_period = 5;
    @(negedge clk);
    gate_sel = 2'b00; start_en = 1'b1;
    @(posedge clk);
    repeat (WAITC + gate_len(0) - 1) @(posedge clk);
    @(posedge clk); #1;
    chk(count_done == 1 && do_pull_low == 0, "R9 pin lags done", do_pull_low, 0);
    @(posedge clk); #1;
    chk(do_pull_low == 1, "R9 pin low after end", do_pull_low, 1);
    @(negedge clk); bus_active = 1'b1;
    @(posedge clk); #1;
    chk(do_pull_low == 0, "R10 released during transfer", do_pull_low, 0);
    @(negedge clk); bus_active = 1'b0;
    @(posedge clk); #1;
    chk(do_pull_low == 1, "R9 low again after transfer", do_pull_low, 1);
    @(negedge clk); start_en = 1'b0;
    @(posedge clk); #1;
    chk(do_pull_low == 1, "R9 pin one cycle behind clear", do_pull_low, 1);
    @(negedge clk); start_en = 1'b1;
    @(posedge clk); #1;
    chk(do_pull_low == 0 && count_done == 0, "R9 released at restart", do_pull_low, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog expired: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule